// File: doc/BRIEF.md
# Prefix-Driven Bank Window Mapper

This block watches the bus of an 8-bit 6502-class processor and maps a 4 KiB CPU window at $A000-$AFFF onto a 1 MiB external memory. Software selects a bank without a register write. It places a three-byte no-op instruction, whose opcode the core treats as a plain no-op, in front of the instruction that should see the bank. The mapper recognises that opcode on opcode-fetch cycles and takes the bank number from the first operand byte. It then places the bank on the upper physical address bits whenever the CPU addresses the window.

There are two kinds of prefix. A data prefix ($FC) overrides the window bank for the accesses of the single next instruction. A jump prefix ($DC) in front of JMP or JSR changes the persistent window bank, so execution continues in the new bank. A JSR taken this way pushes the old bank onto a 128-entry return-bank stack, and the next RTS pops it back. If an interrupt takes the place of the instruction that a prefix was armed for, the pending bank is kept. It is applied to that instruction when RTI returns to it.

The controller uses the following states:
- IDLE: no prefix is in progress.
- OPLO: capture the operand low byte.
- OPHI: skip the high byte.
- ARMED: a bank waits for the next opcode fetch.
- FETCH_RUN: the data-prefix bank is active for one instruction.
- JUMP_RUN: a JMP or JSR is executing, and the new bank commits at the next opcode fetch.
- RET_RUN: an RTS is executing, and the pop commits at the next opcode fetch.

The transitions are:
- IDLE to OPLO on a prefix opcode fetch.
- OPLO to OPHI and OPHI to ARMED, one cycle each.
- ARMED to FETCH_RUN, to JUMP_RUN or to IDLE at the next opcode fetch.
- ARMED to IDLE on an interrupt acknowledge. The bank is saved.
- Any decoding state to RET_RUN on RTS.
- Any decoding state to ARMED on RTI while a saved bank exists.
- Any decoding state to IDLE on any other opcode fetch.

Top module: `mmu_bank_window`

## Requirements
- R1: Any CPU address whose top nibble is not $A appears on phys_addr zero-extended to 20 bits, whatever the mapper state.
- R2: A CPU address $Axxx appears as {bank, xxx}, where bank is the 8-bit bank in effect in that cycle.
- R3: After reset the window bank is 0 and the return-bank stack is empty.
- R4: A data prefix is opcode $FC on a sync cycle. The next bus cycle supplies the bank, and the byte after that is ignored. The bank applies from the next opcode fetch through the end of that one instruction only.
- R5: Bytes $FC or $DC on cycles with sync low never start a prefix.
- R6: A jump prefix is opcode $DC on a sync cycle, with its bank taken as in R4. If the next opcode is JMP ($4C) or JSR ($20), the new bank becomes the persistent window bank from the first opcode fetch after that instruction. With any other opcode, the prefix is dropped.
- R7: A JSR under a jump prefix pushes the previous window bank. An RTS ($60) restores the popped bank from the next opcode fetch onward.
- R8: The stack holds 128 entries. The 129th push overwrites the oldest entry. An RTS with an empty stack leaves the window bank unchanged.
- R9: An interrupt acknowledge on the opcode fetch that an armed prefix was waiting for saves that prefix. The next RTI ($40) re-arms the prefix for the instruction fetched after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | High on opcode-fetch cycles |
| intr_ack | input | 1 | High on the opcode-fetch cycle that an interrupt sequence replaces |
| cpu_addr | input | 16 | CPU address bus |
| bus_data | input | 8 | Byte on the data bus in this cycle |
| phys_addr | output | 20 | Mapped physical address |
| win_hit | output | 1 | CPU address lies inside the window |

## Verification
A wrong internal state shows on phys_addr in the very cycle the CPU next touches $Axxx. A stray prefix, an unpopped stack entry or a lost saved bank puts the wrong upper nibbles on the bus at once. The bench issues whole instruction sequences and checks every bus cycle, so a bank that holds one instruction too long or commits one fetch too early is caught in the cycle where it differs. Return-stack depth faults show only after a long chain of calls and returns, so the wrap and empty-stack cases are driven explicitly.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPLO,
        ST_OPHI,
        ST_ARMED,
        ST_FETCH_RUN,
        ST_JUMP_RUN,
        ST_RET_RUN
    } mmu_state_e;

    typedef enum logic {
        KIND_DATA,
        KIND_JUMP
    } pfx_kind_e;

    localparam logic [7:0] OP_PFX_DATA = 8'hFC;
    localparam logic [7:0] OP_PFX_JUMP = 8'hDC;
    localparam logic [7:0] OP_JSR      = 8'h20;
    localparam logic [7:0] OP_JMP      = 8'h4C;
    localparam logic [7:0] OP_RTS      = 8'h60;
    localparam logic [7:0] OP_RTI      = 8'h40;
endpackage

// File: rtl/mmu_bank_stack.sv
module mmu_bank_stack #(
    parameter int BANK_W = 8,
    parameter int DEPTH  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] top,
    output logic              empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] CNT_MAX = (PTR_W+1)'(DEPTH);

    logic [BANK_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  ptr;
    logic [PTR_W-1:0]  rd_idx;
    logic [PTR_W:0]    count;

    assign rd_idx = ptr - 1'b1;
    assign top    = mem[rd_idx];
    assign empty  = (count == '0);

    always_ff @(posedge clk) begin
        if (push) begin
            mem[ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            count <= '0;
        end else if (push) begin
            ptr <= ptr + 1'b1;
            if (count != CNT_MAX) begin
                count <= count + 1'b1;
            end
        end else if (pop && !empty) begin
            ptr   <= rd_idx;
            count <= count - 1'b1;
        end
    end

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_MAX);
    assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_no_push_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/mmu_seq.sv
module mmu_seq
    import mmu_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              intr_ack,
    input  logic [7:0]        bus_data,
    input  logic              stk_empty,
    input  logic [BANK_W-1:0] stk_top,
    output logic [BANK_W-1:0] eff_bank,
    output logic              push,
    output logic [BANK_W-1:0] push_val,
    output logic              pop
);
    mmu_state_e        state, nxt;
    pfx_kind_e         pend_kind, saved_kind;
    logic [BANK_W-1:0] pend_bank, saved_bank, cur_bank, commit_bank;
    logic              saved_vld, jsr_flag;
    logic              decoding, is_pfx, is_jump_op;

    assign decoding   = sync && (state != ST_OPLO) && (state != ST_OPHI);
    assign is_pfx     = (bus_data == OP_PFX_DATA) || (bus_data == OP_PFX_JUMP);
    assign is_jump_op = (bus_data == OP_JSR) || (bus_data == OP_JMP);
    assign push_val   = cur_bank;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OPLO: nxt = ST_OPHI;
            ST_OPHI: nxt = ST_ARMED;
            default: begin
                if (decoding) begin
                    if (intr_ack) begin
                        nxt = ST_IDLE;
                    end else if (state == ST_ARMED) begin
                        if (pend_kind == KIND_DATA)  nxt = ST_FETCH_RUN;
                        else if (is_jump_op)         nxt = ST_JUMP_RUN;
                        else                         nxt = ST_IDLE;
                    end else if (is_pfx) begin
                        nxt = ST_OPLO;
                    end else if (bus_data == OP_RTS) begin
                        nxt = ST_RET_RUN;
                    end else if (bus_data == OP_RTI && saved_vld) begin
                        nxt = ST_ARMED;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs: commit of deferred bank changes and the bank in effect
    always_comb begin
        commit_bank = cur_bank;
        push        = 1'b0;
        pop         = 1'b0;
        if (sync && state == ST_JUMP_RUN) begin
            commit_bank = pend_bank;
            push        = jsr_flag;
        end else if (sync && state == ST_RET_RUN && !stk_empty) begin
            commit_bank = stk_top;
            pop         = 1'b1;
        end
        eff_bank = commit_bank;
        if (sync && state == ST_ARMED && pend_kind == KIND_DATA && !intr_ack) begin
            eff_bank = pend_bank;
        end else if (!sync && state == ST_FETCH_RUN) begin
            eff_bank = pend_bank;
        end
    end

    // bank registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bank   <= '0;
            pend_bank  <= '0;
            pend_kind  <= KIND_DATA;
            saved_bank <= '0;
            saved_kind <= KIND_DATA;
            saved_vld  <= 1'b0;
            jsr_flag   <= 1'b0;
        end else begin
            cur_bank <= commit_bank;
            if (state == ST_OPLO) begin
                pend_bank <= bus_data[BANK_W-1:0];
            end
            if (decoding) begin
                if (intr_ack) begin
                    if (state == ST_ARMED) begin
                        saved_bank <= pend_bank;
                        saved_kind <= pend_kind;
                        saved_vld  <= 1'b1;
                    end
                end else if (state == ST_ARMED) begin
                    jsr_flag <= (bus_data == OP_JSR);
                end else if (is_pfx) begin
                    pend_kind <= (bus_data == OP_PFX_JUMP) ? KIND_JUMP : KIND_DATA;
                end else if (bus_data == OP_RTI && saved_vld) begin
                    pend_bank <= saved_bank;
                    pend_kind <= saved_kind;
                    saved_vld <= 1'b0;
                end
            end
        end
    end

    assert_nonsync_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && state == ST_IDLE) |=> state == ST_IDLE);
    assert_operand_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_OPLO |=> state == ST_OPHI);
    assert_data_one_instr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && state == ST_ARMED && pend_kind == KIND_DATA && !intr_ack)
        |=> state == ST_FETCH_RUN);
    assert_intr_saves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && state == ST_ARMED && intr_ack) |=> saved_vld);
    assert_bank_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> $stable(cur_bank));
endmodule

// File: rtl/mmu_addr_map.sv
module mmu_addr_map #(
    parameter int          CPU_AW  = 16,
    parameter int          OFS_W   = 12,
    parameter int          BANK_W  = 8,
    parameter logic [3:0]  WIN_TAG = 4'hA
) (
    input  logic [CPU_AW-1:0]       cpu_addr,
    input  logic [BANK_W-1:0]       bank,
    output logic [BANK_W+OFS_W-1:0] phys_addr,
    output logic                    win_hit
);
    localparam int PA_W = BANK_W + OFS_W;

    assign win_hit = (cpu_addr[CPU_AW-1:OFS_W] == WIN_TAG);

    always_comb begin
        if (win_hit) phys_addr = {bank, cpu_addr[OFS_W-1:0]};
        else         phys_addr = {{(PA_W-CPU_AW){1'b0}}, cpu_addr};
    end
endmodule

// File: rtl/mmu_bank_window.sv
module mmu_bank_window #(
    parameter int BANK_W  = 8,
    parameter int DEPTH   = 128,
    parameter int CPU_AW  = 16,
    parameter int OFS_W   = 12,
    localparam int PA_W   = BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync,
    input  logic              intr_ack,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [7:0]        bus_data,
    output logic [PA_W-1:0]   phys_addr,
    output logic              win_hit
);
    logic [BANK_W-1:0] eff_bank, push_val, stk_top;
    logic              push, pop, stk_empty;

    mmu_seq #(.BANK_W(BANK_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .sync(sync), .intr_ack(intr_ack),
        .bus_data(bus_data), .stk_empty(stk_empty), .stk_top(stk_top),
        .eff_bank(eff_bank), .push(push), .push_val(push_val), .pop(pop)
    );

    mmu_bank_stack #(.BANK_W(BANK_W), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .din(push_val), .top(stk_top), .empty(stk_empty)
    );

    mmu_addr_map #(.CPU_AW(CPU_AW), .OFS_W(OFS_W), .BANK_W(BANK_W)) u_map (
        .cpu_addr(cpu_addr), .bank(eff_bank),
        .phys_addr(phys_addr), .win_hit(win_hit)
    );

    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> phys_addr[PA_W-1:CPU_AW] == '0 && phys_addr[CPU_AW-1:0] == cpu_addr);
    assert_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]);
endmodule

// File: tb/mmu_bank_window_test.sv
module mmu_bank_window_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        intr_ack = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  bus_data = 8'h00;
    logic [19:0] phys_addr;
    logic        win_hit;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int cur = 0;
    int stk[$];
    bit armed = 0, a_jump = 0;
    int abank = 0;
    bit frun = 0;
    int fbank = 0;
    bit jpend = 0, jjsr = 0;
    int jbank = 0;
    bit rpend = 0;
    int phase = 0;
    bit p_jump = 0;
    int pbank = 0;
    bit sv = 0, s_jump = 0;
    int sbank = 0;

    always #10 clk = ~clk;

    mmu_bank_window uut (
        .clk(clk), .rst_n(rst_n), .sync(sync), .intr_ack(intr_ack),
        .cpu_addr(cpu_addr), .bus_data(bus_data),
        .phys_addr(phys_addr), .win_hit(win_hit)
    );

    function automatic logic [19:0] expect_map(int bank, logic [15:0] a);
        logic [7:0] b;
        b = bank[7:0];
        if (a[15:12] == 4'hA) return {b, a[11:0]};
        return {4'h0, a};
    endfunction

    task automatic check(string tag, logic [19:0] exp);
        checks++;
        if (phys_addr !== exp) begin
            errors++;
            $display("FAIL %s: phys_addr=%h expected %h (addr %h)", tag, phys_addr, exp, cpu_addr);
        end
    endtask

    task automatic opf(logic [7:0] op, logic [15:0] a, bit ack, string tag);
        int bank;
        @(negedge clk);
        sync = 1'b1; intr_ack = ack; bus_data = op; cpu_addr = a;
        if (jpend) begin
            if (jjsr) begin
                stk.push_back(cur);
                if (stk.size() > 128) void'(stk.pop_front());
            end
            cur = jbank;
        end
        if (rpend && stk.size() > 0) cur = stk.pop_back();
        jpend = 0; rpend = 0; frun = 0;
        bank = cur;
        if (!ack && armed && !a_jump) bank = abank;
        #1 check(tag, expect_map(bank, a));
        if (ack) begin
            if (armed) begin sv = 1; s_jump = a_jump; sbank = abank; end
            armed = 0;
        end else if (armed) begin
            if (!a_jump) begin frun = 1; fbank = abank; end
            else if (op == 8'h20 || op == 8'h4C) begin
                jpend = 1; jjsr = (op == 8'h20); jbank = abank;
            end
            armed = 0;
        end else if (op == 8'hFC || op == 8'hDC) begin
            phase = 1; p_jump = (op == 8'hDC);
        end else if (op == 8'h60) begin
            rpend = 1;
        end else if (op == 8'h40 && sv) begin
            armed = 1; a_jump = s_jump; abank = sbank; sv = 0;
        end
    endtask

    task automatic acc(logic [15:0] a, logic [7:0] d, string tag);
        int bank;
        @(negedge clk);
        sync = 1'b0; intr_ack = 1'b0; bus_data = d; cpu_addr = a;
        bank = frun ? fbank : cur;
        #1 check(tag, expect_map(bank, a));
        if (phase == 1) begin pbank = d; phase = 2; end
        else if (phase == 2) begin phase = 0; armed = 1; a_jump = p_jump; abank = pbank; end
    endtask

    task automatic prefix(bit jump, logic [7:0] lo, logic [7:0] hi, string tag);
        opf(jump ? 8'hDC : 8'hFC, 16'h1FA9, 1'b0, tag);
        acc(16'h1FAA, lo, tag);
        acc(16'h1FAB, hi, tag);
        acc(16'h0022, 8'h00, tag);
    endtask

    task automatic call(logic [7:0] bank, logic [7:0] op, string tag);
        prefix(1'b1, bank, 8'h00, tag);
        opf(op, 16'h1FC0, 1'b0, tag);
        acc(16'h1FC1, 8'h00, tag);
        acc(16'h1FC2, 8'hA2, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3 reset state, R1 pass-through, R2 mapping
        acc(16'hA123, 8'h00, "R3");
        acc(16'h1234, 8'h00, "R1");
        acc(16'hB000, 8'h00, "R1");
        acc(16'h9FFF, 8'h00, "R1");
        acc(16'hAFFF, 8'h00, "R2");
        // R4 data prefix, one instruction only
        prefix(1'b0, 8'h22, 8'h00, "R4");
        opf(8'hBD, 16'h1FAC, 1'b0, "R4");
        acc(16'h1FAD, 8'h05, "R4");
        acc(16'h1FAE, 8'hA0, "R4");
        acc(16'hA005, 8'h00, "R2");
        opf(8'hE8, 16'h1FAF, 1'b0, "R4");
        acc(16'hA005, 8'h00, "R4");
        // R4 upper operand byte ignored
        prefix(1'b0, 8'h37, 8'hFF, "R4");
        opf(8'hAD, 16'h1FB0, 1'b0, "R4");
        acc(16'hA010, 8'h00, "R4");
        // R5 prefix bytes on data cycles
        opf(8'hA9, 16'h1FB1, 1'b0, "R5");
        acc(16'h1FB2, 8'hFC, "R5");
        opf(8'hA9, 16'h1FB3, 1'b0, "R5");
        acc(16'h1FB4, 8'hDC, "R5");
        acc(16'h1FB5, 8'h22, "R5");
        opf(8'hAD, 16'h1FB6, 1'b0, "R5");
        acc(16'hA100, 8'h00, "R5");
        // R6/R7 nested calls and returns
        call(8'h11, 8'h20, "R6");
        acc(16'h01FF, 8'h1F, "R7");
        opf(8'hA9, 16'hA200, 1'b0, "R6");
        acc(16'hA201, 8'h00, "R6");
        call(8'h10, 8'h20, "R7");
        opf(8'hEA, 16'hA300, 1'b0, "R7");
        opf(8'h60, 16'hA301, 1'b0, "R7");
        acc(16'h01FD, 8'h00, "R7");
        opf(8'hEA, 16'hA210, 1'b0, "R7");
        opf(8'h60, 16'hA211, 1'b0, "R7");
        opf(8'hEA, 16'h1FC3, 1'b0, "R7");
        acc(16'hA000, 8'h00, "R7");
        // R6 jump prefix dropped by a non-jump opcode
        prefix(1'b1, 8'h44, 8'h00, "R6");
        opf(8'hAD, 16'h1FD0, 1'b0, "R6");
        acc(16'hA050, 8'h00, "R6");
        opf(8'hEA, 16'h1FD3, 1'b0, "R6");
        acc(16'hA050, 8'h00, "R6");
        // R6 JMP, then R8 return with empty stack
        call(8'h05, 8'h4C, "R6");
        opf(8'hEA, 16'hA400, 1'b0, "R6");
        opf(8'h60, 16'hA401, 1'b0, "R8");
        acc(16'h01FE, 8'h00, "R8");
        opf(8'hEA, 16'hA402, 1'b0, "R8");
        acc(16'hA0F0, 8'h00, "R8");
        // R9 interrupt after a data prefix
        prefix(1'b0, 8'h22, 8'h00, "R9");
        opf(8'hBD, 16'h1FE0, 1'b1, "R9");
        acc(16'h01FF, 8'h00, "R9");
        opf(8'hEA, 16'hA700, 1'b0, "R9");
        acc(16'hA000, 8'h00, "R9");
        opf(8'h40, 16'hA701, 1'b0, "R9");
        acc(16'h01FC, 8'h00, "R9");
        opf(8'hBD, 16'h1FE0, 1'b0, "R9");
        acc(16'hA0FF, 8'h00, "R9");
        opf(8'hEA, 16'h1FE3, 1'b0, "R9");
        acc(16'hA0FF, 8'h00, "R9");
        // R8 overflow wrap and drain
        call(8'h00, 8'h4C, "R8");
        for (int i = 0; i < 130; i++) begin
            call(8'(i + 1), 8'h20, "R8");
        end
        opf(8'hEA, 16'hA000, 1'b0, "R8");
        for (int i = 0; i < 131; i++) begin
            opf(8'h60, 16'hA001, 1'b0, "R8");
            acc(16'hA800, 8'h00, "R8");
        end
        opf(8'hEA, 16'hA900, 1'b0, "R8");
        acc(16'hA901, 8'h00, "R8");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule